// File: doc/BRIEF.md
# Frame Buffer Rectangle Transfer Engine

The engine copies a rectangle of 16-bit pixels between a 32-bit word stream and a frame buffer 1024 pixels wide and 512 lines tall. A transfer opens with three words on the input stream: a command word, whose top byte selects the direction, then a position word, then a size word. While the transfer runs, the engine walks the rectangle in raster order and produces one frame-buffer address per pixel. Each 32-bit word carries two pixels.

In the write direction the engine takes data words from the same input stream. Bit 15 of every stored pixel is forced high when the mask input is set. In the read direction the engine fetches pixels from the frame buffer, packs them two to a word, and offers each word on a valid/ready output. The rectangle wraps at the right and bottom edges of the frame buffer. A busy output covers the whole transfer, from the size word to the last pixel.

The frame-buffer RAM is external. It is a simple synchronous memory with a write enable, a read enable, a 19-bit address and read data that arrives one cycle after the read enable.

Top module: `vram_xfer_engine`

## Requirements
- R1: A command word whose byte 31:24 lies in 0xA0..0xBF (bits 7:5 = 3'b101) starts a write into the frame buffer. Any command byte outside 0xA0..0xDF is consumed and discarded. A discarded command makes no memory access and leaves busy_o low.
- R2: A command byte in 0xC0..0xDF (bits 7:5 = 3'b110) starts a read from the frame buffer. A read transfer never asserts mem_we_o.
- R3: busy_o stays low after the command word and after the position word. It rises in the cycle after the size word is accepted, and it stays high until the transfer completes.
- R4: The start X is bits 9:0 of the position word and the start Y is bits 24:16. All other bits of the position word are ignored. Each pixel address on mem_addr_o is Y*1024+X, so bits 18:10 hold the line and bits 9:0 hold the column.
- R5: Width is ((size-1) & 0x3FF)+1 and height is (((size>>16)-1) & 0x1FF)+1, with size taken as a 32-bit value. A field of zero therefore gives 1024 pixels of width or 512 lines of height.
- R6: Pixels follow raster order, left to right along a line and then down to the next line. In a data word, bits 15:0 hold the earlier pixel and bits 31:16 the later one, and a single word may span the end of one line and the start of the next. The two pixels of a write word are written in consecutive cycles.
- R7: On a write, each stored pixel equals the data pixel with bit 15 ORed with mask_set_i. With mask_set_i low, the data is stored unchanged, including a bit 15 that is already set.
- R8: Data words may arrive with idle gaps, including gaps in the middle of a line. The transfer then continues at the saved column with no pixel lost or repeated.
- R9: Columns wrap modulo 1024 and lines wrap modulo 512 when the rectangle crosses an edge.
- R10: A read word carries the earlier pixel in bits 15:0 and the later pixel in bits 31:16. When the pixel count is odd, the final word has bits 31:16 equal to zero.
- R11: When a write has an odd pixel count, the upper half of its final data word is discarded. busy_o falls after the last pixel is written, and the next input word is decoded as a command.
- R12: During a read, word_ready_o is low. rd_data_o holds steady while rd_valid_o is high and rd_ready_i is low. busy_o falls once the final read word has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Input stream word valid |
| word_data_i | input | 32 | Input stream word: command, position, size or write data |
| word_ready_o | output | 1 | Engine accepts the input word this cycle |
| mask_set_i | input | 1 | Force bit 15 of written pixels |
| busy_o | output | 1 | Transfer in progress |
| rd_valid_o | output | 1 | Read word available |
| rd_data_o | output | 32 | Read word, two pixels |
| rd_ready_i | input | 1 | Consumer takes the read word |
| mem_we_o | output | 1 | Frame buffer write enable |
| mem_re_o | output | 1 | Frame buffer read enable |
| mem_addr_o | output | 19 | Frame buffer pixel address, line in 18:10, column in 9:0 |
| mem_wdata_o | output | 16 | Frame buffer write pixel |
| mem_rdata_i | input | 16 | Frame buffer read pixel, one cycle after mem_re_o |

## Verification
The write path is tried with several rectangle shapes. An even-width 4x2 block with junk in the unused position and size bits shows that the fields are extracted correctly and that pixels come out in order. An odd 3x3 block with pauses between words separates column resume from line stepping and shows that the odd final half is dropped. A block at the corner of the frame buffer shows the wrap at both edges. Zero-valued size fields give a 1024x1 strip and a 1x512 column, which exercise the maximum width and the maximum height. Reads cover an area that was never written, the odd block read back while the consumer stalls, and the wrapped corner. These show the half-word order, the zero padding and the output hold under backpressure, and they confirm the mask bit that was stored. Discarded command bytes just outside the transfer range confirm that nothing reaches memory.

// File: rtl/vxe_pkg.sv
package vxe_pkg;

  typedef enum logic [1:0] {
    HDR_CMD,
    HDR_POS,
    HDR_SIZE
  } hdr_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WR,
    SQ_RD_A,
    SQ_RD_B,
    SQ_RD_C,
    SQ_RD_OUT
  } seq_state_e;

  function automatic logic is_xfer_cmd(logic [7:0] c);
    return (c[7:5] == 3'b101) || (c[7:5] == 3'b110);
  endfunction

  function automatic logic is_read_cmd(logic [7:0] c);
    return c[7:5] == 3'b110;
  endfunction

endpackage

// File: rtl/vxe_cmd_decode.sv
module vxe_cmd_decode
  import vxe_pkg::*;
#(
  parameter int X_BITS   = 10,
  parameter int Y_BITS   = 9,
  parameter int PIX_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  word_valid_i,
  input  logic [2*PIX_BITS-1:0] word_data_i,
  input  logic                  accept_i,
  output logic                  start_o,
  output logic                  read_o,
  output logic [X_BITS-1:0]     x0_o,
  output logic [Y_BITS-1:0]     y0_o,
  output logic [X_BITS-1:0]     w_m1_o,
  output logic [Y_BITS-1:0]     h_m1_o
);
  localparam int WORD_BITS = 2 * PIX_BITS;
  localparam int CMD_LSB   = WORD_BITS - 8;

  hdr_state_e        st_q;
  logic              rd_q;
  logic [X_BITS-1:0] x0_q;
  logic [Y_BITS-1:0] y0_q;
  logic              fire;
  logic [7:0]        cmd_byte;

  assign fire     = word_valid_i & accept_i;
  assign cmd_byte = word_data_i[CMD_LSB +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= HDR_CMD;
      rd_q <= 1'b0;
      x0_q <= '0;
      y0_q <= '0;
    end else if (fire) begin
      case (st_q)
        HDR_CMD: begin
          // non-transfer commands are swallowed here
          if (is_xfer_cmd(cmd_byte)) begin
            rd_q <= is_read_cmd(cmd_byte);
            st_q <= HDR_POS;
          end
        end
        HDR_POS: begin
          x0_q <= word_data_i[X_BITS-1:0];
          y0_q <= word_data_i[PIX_BITS +: Y_BITS];
          st_q <= HDR_SIZE;
        end
        HDR_SIZE: st_q <= HDR_CMD;
        default:  st_q <= HDR_CMD;
      endcase
    end
  end

  // minus-one encoding: a zero field wraps to the maximum extent
  assign w_m1_o  = word_data_i[X_BITS-1:0] - X_BITS'(1);
  assign h_m1_o  = word_data_i[PIX_BITS +: Y_BITS] - Y_BITS'(1);
  assign start_o = fire && (st_q == HDR_SIZE);
  assign read_o  = rd_q;
  assign x0_o    = x0_q;
  assign y0_o    = y0_q;

  logic unused_bits;
  assign unused_bits = ^{word_data_i[CMD_LSB-1:PIX_BITS+Y_BITS],
                         word_data_i[PIX_BITS-1:X_BITS]};

  AST_POS_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HDR_POS) |-> ($past(st_q) != HDR_SIZE)); // R3

endmodule

// File: rtl/vxe_addr_walker.sv
module vxe_addr_walker #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [X_BITS-1:0]        x0_i,
  input  logic [Y_BITS-1:0]        y0_i,
  input  logic [X_BITS-1:0]        w_m1_i,
  input  logic [Y_BITS-1:0]        h_m1_i,
  input  logic                     step_i,
  output logic [X_BITS+Y_BITS-1:0] addr_o,
  output logic                     last_o
);
  logic [X_BITS-1:0] x0_q, wm1_q, col_q;
  logic [Y_BITS-1:0] y0_q, hm1_q, row_q;
  logic              eol;
  logic [X_BITS-1:0] col_x;
  logic [Y_BITS-1:0] row_y;

  assign eol    = (col_q == wm1_q);
  assign last_o = eol && (row_q == hm1_q);
  // truncating adds give the edge wrap
  assign col_x  = x0_q + col_q;
  assign row_y  = y0_q + row_q;
  assign addr_o = {row_y, col_x};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_q  <= '0;
      y0_q  <= '0;
      wm1_q <= '0;
      hm1_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (load_i) begin
      x0_q  <= x0_i;
      y0_q  <= y0_i;
      wm1_q <= w_m1_i;
      hm1_q <= h_m1_i;
      col_q <= '0;
      row_q <= '0;
    end else if (step_i && !last_o) begin
      if (eol) begin
        col_q <= '0;
        row_q <= row_q + Y_BITS'(1);
      end else begin
        col_q <= col_q + X_BITS'(1);
      end
    end
  end

  AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_q <= wm1_q) && (row_q <= hm1_q)); // R5

endmodule

// File: rtl/vxe_pixel_seq.sv
module vxe_pixel_seq
  import vxe_pkg::*;
#(
  parameter int PIX_BITS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  read_i,
  input  logic                  word_valid_i,
  input  logic [2*PIX_BITS-1:0] word_data_i,
  input  logic                  mask_set_i,
  input  logic                  last_i,
  input  logic [PIX_BITS-1:0]   mem_rdata_i,
  input  logic                  rd_ready_i,
  output logic                  busy_o,
  output logic                  take_o,
  output logic                  step_o,
  output logic                  mem_we_o,
  output logic                  mem_re_o,
  output logic [PIX_BITS-1:0]   mem_wdata_o,
  output logic                  rd_valid_o,
  output logic [2*PIX_BITS-1:0] rd_data_o
);
  seq_state_e            st_q;
  logic                  pend_q, half_q, lone_q, fin_q;
  logic [2*PIX_BITS-1:0] word_q;
  logic [PIX_BITS-1:0]   lo_q, hi_q;
  logic [PIX_BITS-1:0]   pix_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      pend_q <= 1'b0;
      half_q <= 1'b0;
      lone_q <= 1'b0;
      fin_q  <= 1'b0;
      word_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            st_q   <= read_i ? SQ_RD_A : SQ_WR;
            pend_q <= 1'b0;
          end
        end
        SQ_WR: begin
          if (!pend_q) begin
            if (word_valid_i) begin
              word_q <= word_data_i;
              pend_q <= 1'b1;
              half_q <= 1'b0;
            end
          end else if (last_i) begin
            // odd tail: upper half of the word is dropped
            pend_q <= 1'b0;
            st_q   <= SQ_IDLE;
          end else if (half_q) begin
            pend_q <= 1'b0;
          end else begin
            half_q <= 1'b1;
          end
        end
        SQ_RD_A: begin
          lone_q <= last_i;
          st_q   <= SQ_RD_B;
        end
        SQ_RD_B: begin
          lo_q <= mem_rdata_i;
          if (lone_q) begin
            hi_q  <= '0;
            fin_q <= 1'b1;
            st_q  <= SQ_RD_OUT;
          end else begin
            fin_q <= last_i;
            st_q  <= SQ_RD_C;
          end
        end
        SQ_RD_C: begin
          hi_q <= mem_rdata_i;
          st_q <= SQ_RD_OUT;
        end
        SQ_RD_OUT: begin
          if (rd_ready_i) st_q <= fin_q ? SQ_IDLE : SQ_RD_A;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    pix_sel     = half_q ? word_q[2*PIX_BITS-1:PIX_BITS] : word_q[PIX_BITS-1:0];
    mem_wdata_o = pix_sel | {mask_set_i, {(PIX_BITS-1){1'b0}}};
    mem_we_o    = (st_q == SQ_WR) && pend_q;
    mem_re_o    = (st_q == SQ_RD_A) || ((st_q == SQ_RD_B) && !lone_q);
    step_o      = mem_we_o || mem_re_o;
    take_o      = (st_q == SQ_WR) && !pend_q;
    busy_o      = (st_q != SQ_IDLE);
    rd_valid_o  = (st_q == SQ_RD_OUT);
    rd_data_o   = {hi_q, lo_q};
  end

  AST_WR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !half_q && !last_i) |=> mem_we_o); // R6

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R12

  AST_RD_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && lone_q) |-> (rd_data_o[2*PIX_BITS-1:PIX_BITS] == '0)); // R10

endmodule

// File: rtl/vram_xfer_engine.sv
module vram_xfer_engine #(
  parameter int X_BITS   = 10,
  parameter int Y_BITS   = 9,
  parameter int PIX_BITS = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     word_valid_i,
  input  logic [2*PIX_BITS-1:0]    word_data_i,
  output logic                     word_ready_o,
  input  logic                     mask_set_i,
  output logic                     busy_o,
  output logic                     rd_valid_o,
  output logic [2*PIX_BITS-1:0]    rd_data_o,
  input  logic                     rd_ready_i,
  output logic                     mem_we_o,
  output logic                     mem_re_o,
  output logic [X_BITS+Y_BITS-1:0] mem_addr_o,
  output logic [PIX_BITS-1:0]      mem_wdata_o,
  input  logic [PIX_BITS-1:0]      mem_rdata_i
);
  logic              start, rd_dir, take, step, last;
  logic [X_BITS-1:0] x0, w_m1;
  logic [Y_BITS-1:0] y0, h_m1;

  vxe_cmd_decode #(
    .X_BITS  (X_BITS),
    .Y_BITS  (Y_BITS),
    .PIX_BITS(PIX_BITS)
  ) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_valid_i(word_valid_i),
    .word_data_i (word_data_i),
    .accept_i    (!busy_o),
    .start_o     (start),
    .read_o      (rd_dir),
    .x0_o        (x0),
    .y0_o        (y0),
    .w_m1_o      (w_m1),
    .h_m1_o      (h_m1)
  );

  vxe_addr_walker #(
    .X_BITS(X_BITS),
    .Y_BITS(Y_BITS)
  ) u_walk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .x0_i  (x0),
    .y0_i  (y0),
    .w_m1_i(w_m1),
    .h_m1_i(h_m1),
    .step_i(step),
    .addr_o(mem_addr_o),
    .last_o(last)
  );

  vxe_pixel_seq #(
    .PIX_BITS(PIX_BITS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .read_i      (rd_dir),
    .word_valid_i(word_valid_i),
    .word_data_i (word_data_i),
    .mask_set_i  (mask_set_i),
    .last_i      (last),
    .mem_rdata_i (mem_rdata_i),
    .rd_ready_i  (rd_ready_i),
    .busy_o      (busy_o),
    .take_o      (take),
    .step_o      (step),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  assign word_ready_o = !busy_o || take;

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy_o); // R3

  AST_READ_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_re_o) |-> !word_ready_o); // R12

  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_dir) |-> !mem_we_o); // R2

endmodule

// File: tb/vram_xfer_engine_bench.sv
module vram_xfer_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o;
  logic        mask_set_i = 1'b0;
  logic        busy_o;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        rd_ready_i = 1'b1;
  logic        mem_we_o, mem_re_o;
  logic [18:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  vram_xfer_engine u_vram_xfer_engine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .mask_set_i(mask_set_i), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ready_i(rd_ready_i),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  typedef struct { logic [18:0] a; logic [15:0] d; string tag; } wr_item_t;
  typedef struct { logic [31:0] d; string tag; } rd_item_t;
  wr_item_t wq[$];
  rd_item_t rq[$];
  logic [15:0] fb[int];      // memory model, written by the design
  logic [15:0] exp_fb[int];  // bench expectation of memory contents

  function automatic logic [15:0] init_pix(int a);
    return 16'(a * 7) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] pd(int seed, int k);
    return 16'(seed * 961 + k * 40503);
  endfunction

  function automatic logic [15:0] exp_pix(int a);
    if (exp_fb.exists(a)) return exp_fb[a];
    return init_pix(a);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // synchronous frame buffer, one-cycle read latency
  always @(posedge clk_i) begin
    if (mem_re_o)
      mem_rdata_i <= fb.exists(int'(mem_addr_o)) ? fb[int'(mem_addr_o)] : init_pix(int'(mem_addr_o));
    if (mem_we_o) fb[int'(mem_addr_o)] = mem_wdata_o;
  end

  // read consumer with optional stalls
  bit stall_mode = 0;
  int cyc = 0;
  always @(posedge clk_i) begin
    #2;
    cyc++;
    rd_ready_i = !stall_mode || (cyc % 3 != 0);
  end

  // monitor: pops the scoreboard as the design produces results
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (mem_we_o) begin
        if (wq.size() == 0) chk("R1 R2 unexpected write", {45'd0, mem_addr_o}, 64'hFFFF_FFFF);
        else begin
          wr_item_t it;
          it = wq.pop_front();
          chk({it.tag, " addr"}, {45'd0, mem_addr_o}, {45'd0, it.a});
          chk({it.tag, " data"}, {48'd0, mem_wdata_o}, {48'd0, it.d});
        end
      end
      if (rd_valid_o && rd_ready_i) begin
        if (rq.size() == 0) chk("R12 unexpected read word", {32'd0, rd_data_o}, 64'hFFFF_FFFF_FFFF);
        else begin
          rd_item_t it;
          it = rq.pop_front();
          chk(it.tag, {32'd0, rd_data_o}, {32'd0, it.d});
        end
      end
    end
  end

  task automatic send(logic [31:0] d);
    @(negedge clk_i);
    word_valid_i = 1'b1;
    word_data_i  = d;
    while (!word_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    word_valid_i = 1'b0;
  endtask

  task automatic header(logic [7:0] cmd, int x, int y, logic [31:0] sz);
    send({cmd, 24'h0});
    chk("R3 busy after command", {63'd0, busy_o}, 64'd0);
    send({7'h55, 9'(y), 6'h2A, 10'(x)});
    chk("R3 busy after position", {63'd0, busy_o}, 64'd0);
    send(sz);
    chk("R3 busy after size", {63'd0, busy_o}, 64'd1);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic do_write(logic [7:0] cmd, int x, int y, logic [31:0] sz, int seed,
                          logic mask, int pause, string tag);
    int w, h, n, nw;
    w  = int'(((sz - 1) & 32'h3FF) + 1);
    h  = int'((((sz >> 16) - 1) & 32'h1FF) + 1);
    n  = w * h;
    nw = (n + 1) / 2;
    mask_set_i = mask;
    for (int k = 0; k < n; k++) begin
      wr_item_t it;
      it.a = 19'((((y + k / w) & 511) * 1024) + ((x + k % w) & 1023));
      it.d = pd(seed, k) | {mask, 15'd0};
      it.tag = tag;
      wq.push_back(it);
      exp_fb[int'(it.a)] = it.d;
    end
    header(cmd, x, y, sz);
    for (int j = 0; j < nw; j++) begin
      send({pd(seed, 2 * j + 1), pd(seed, 2 * j)});
      if (pause > 0 && (j % pause) == 0) repeat (5) @(negedge clk_i);
    end
    wait_idle();
    chk({tag, " R11 all pixels written"}, 64'(wq.size()), 64'd0);
    chk({tag, " R11 ready for next command"}, {63'd0, word_ready_o}, 64'd1);
  endtask

  task automatic do_read(logic [7:0] cmd, int x, int y, logic [31:0] sz, bit stall, string tag);
    int w, h, n, nw;
    w  = int'(((sz - 1) & 32'h3FF) + 1);
    h  = int'((((sz >> 16) - 1) & 32'h1FF) + 1);
    n  = w * h;
    nw = (n + 1) / 2;
    for (int j = 0; j < nw; j++) begin
      rd_item_t it;
      int a0, a1;
      a0 = (((y + (2 * j) / w) & 511) * 1024) + ((x + (2 * j) % w) & 1023);
      a1 = (((y + (2 * j + 1) / w) & 511) * 1024) + ((x + (2 * j + 1) % w) & 1023);
      it.d = {(2 * j + 1 < n) ? exp_pix(a1) : 16'h0000, exp_pix(a0)};
      it.tag = tag;
      rq.push_back(it);
    end
    stall_mode = stall;
    header(cmd, x, y, sz);
    chk({tag, " R12 input stalled during read"}, {63'd0, word_ready_o}, 64'd0);
    wait_idle();
    stall_mode = 0;
    chk({tag, " R12 all words delivered"}, 64'(rq.size()), 64'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired before the run completed");
    done = 1;
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R3 reset busy", {63'd0, busy_o}, 64'd0);
    chk("R3 reset ready", {63'd0, word_ready_o}, 64'd1);
    chk("R12 reset rd_valid", {63'd0, rd_valid_o}, 64'd0);
    chk("R1 reset mem_we", {63'd0, mem_we_o}, 64'd0);

    // R1: bytes just outside the transfer range are discarded
    send(32'h9F00_0000);
    chk("R1 ignored 0x9F", {63'd0, busy_o}, 64'd0);
    send(32'hE100_0000);
    chk("R1 ignored 0xE1", {63'd0, busy_o}, 64'd0);
    send(32'h8000_0000);
    chk("R1 ignored 0x80", {63'd0, busy_o}, 64'd0);

    do_write(8'hA0, 10, 20, {16'hFE02, 16'hFC04}, 1, 1'b0, 0, "R1 R4 R6 block 4x2");
    do_write(8'hBF, 3, 40, {16'h0003, 16'h0003}, 2, 1'b1, 2, "R7 R8 R11 block 3x3");
    do_write(8'hA5, 1022, 511, {16'h0002, 16'h0004}, 3, 1'b0, 0, "R9 corner wrap");
    do_write(8'hB0, 5, 100, {16'h0001, 16'h0000}, 4, 1'b0, 0, "R5 width 1024");
    do_write(8'hA0, 700, 3, {16'h0000, 16'h0001}, 5, 1'b1, 0, "R5 height 512");

    do_read(8'hC0, 100, 7, {16'h0001, 16'h0004}, 1'b0, "R2 R10 untouched area");
    do_read(8'hDF, 3, 40, {16'h0003, 16'h0003}, 1'b1, "R10 R12 R7 odd block stalled");
    do_read(8'hCC, 1022, 511, {16'h0002, 16'h0004}, 1'b0, "R9 R2 corner readback");

    repeat (4) @(negedge clk_i);
    done = 1;
    finish_run();
  end

endmodule